// File: doc/BRIEF.md
# Banked Memory Window Mapper

This block sits between a CPU with a 16-bit address bus and a memory system made of 256 KB of RAM, 16 KB of ROM and a 4 KB video region. The address space is cut into sixteen 4 KB windows, selected by address bits 15..12. A 6-bit control register is loaded from an I/O port write. Each access is then steered to one target, decoded from that register and the window number: a RAM page, a ROM page, or one half of the video region.

Reads and writes use separate decode outputs. A window that reads ROM does not store writes: a write to it raises a discard flag and enables nothing else. The video region and ROM can each be switched off, and the video region can be moved between two windows. When more than one target claims a window, video wins over ROM and ROM wins over RAM. The decode is combinational from the registered control value, so a new control value applies from the cycle after it is written.

Top module: `bank_window_mapper`

## Requirements
- R1: After reset the control register is 0. A read at 0x8000 hits ROM at ROM address 0x0000, window 0xF hits video, and window 0x0 hits RAM page 0.
- R2: Only data bits 5..0 are stored on a control write. Bits 7..6 have no effect on any decode.
- R3: A RAM window in the lower half (address bit 15 = 0) maps to RAM address {S5, S1, S0, A14..A12, A11..A0}. The bank bit from S5 is therefore zero whenever S5 is clear. A RAM window in the upper half uses the fixed bank 3, giving RAM address {3'b011, A14..A12, A11..A0}.
- R4: When control bit 2 is 1, ROM is disabled and windows 0x8..0xB fall through to RAM.
- R5: When control bit 3 is 1, video is disabled and its window falls through to ROM if ROM claims it, otherwise to RAM.
- R6: Control bit 4 selects the video window: 0 places it at window 0xF, 1 places it at window 0x8.
- R7: Video wins over ROM, which wins over RAM. At most one read target is active at a time.
- R8: With ROM enabled, a read in windows 0x8..0xB hits ROM at address {window & 3, A11..A0}.
- R9: A write to a ROM window raises wr_discard_o and enables no RAM or video write. At most one write target is active at a time.
- R10: Within the video window, A11 = 0 asserts the low-half strobe and A11 = 1 asserts the high-half strobe.
- R11: A control write takes effect from the next clock edge. Read outputs are active only while mem_rd_i is 1, and write outputs only while mem_wr_i is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| latch_we_i | input | 1 | Control register write strobe |
| latch_data_i | input | 8 | Control write data (bits 5..0 used) |
| cpu_addr_i | input | 16 | CPU address |
| mem_rd_i | input | 1 | Memory read cycle |
| mem_wr_i | input | 1 | Memory write cycle |
| rd_ram_en_o | output | 1 | Read targets RAM |
| rd_ram_addr_o | output | 18 | Physical RAM address for reads |
| rd_rom_en_o | output | 1 | Read targets ROM |
| rd_rom_addr_o | output | 14 | ROM address for reads |
| rd_vid_lo_o | output | 1 | Read targets video low half |
| rd_vid_hi_o | output | 1 | Read targets video high half |
| wr_ram_en_o | output | 1 | Write targets RAM |
| wr_ram_addr_o | output | 18 | Physical RAM address for writes |
| wr_discard_o | output | 1 | Write to a ROM window, dropped |
| wr_vid_lo_o | output | 1 | Write targets video low half |
| wr_vid_hi_o | output | 1 | Write targets video high half |

## Verification
The bench uses the package defaults: a 3-bit bank select, ROM in windows 0x8..0xB, video at window 0xF or 0x8, and fixed upper bank 3. With these defaults every lower-half bank 0..7 is reachable, up to the top RAM page 63 at address 0x3FFFF. The defaults also produce all three priority clashes: video over ROM at window 0x8, ROM falling through to RAM, and video falling through to ROM or RAM. Vectors pair control values, including ones with the unused high bits set, with addresses on both video halves and on the first and last ROM windows. Directed steps cover the one-cycle delay of a control write and the gating of the outputs by the read and write strobes.

// File: rtl/mapper_pkg.sv
package mapper_pkg;
  localparam int ADDR_W   = 16;
  localparam int WIN_W    = 4;
  localparam int OFF_W    = ADDR_W - WIN_W;
  localparam int BANK_W   = 3;
  localparam int ROM_PG_W = 2;
  localparam int RAM_AW   = BANK_W + WIN_W - 1 + OFF_W;
  localparam int ROM_AW   = ROM_PG_W + OFF_W;
  localparam int CTL_W    = 6;

  localparam logic [WIN_W-1:0]  ROM_WIN_FIRST = 4'h8;
  localparam logic [WIN_W-1:0]  ROM_WIN_LAST  = 4'hB;
  localparam logic [WIN_W-1:0]  VID_WIN_DEF   = 4'hF;
  localparam logic [WIN_W-1:0]  VID_WIN_ALT   = 4'h8;
  localparam logic [BANK_W-1:0] UPPER_BANK    = 3'd3;

  // control bit positions
  localparam int CB_BANK0    = 0;
  localparam int CB_BANK1    = 1;
  localparam int CB_ROM_OFF  = 2;
  localparam int CB_VID_OFF  = 3;
  localparam int CB_VID_MOVE = 4;
  localparam int CB_BANK2    = 5;

  typedef enum logic [1:0] {
    SRC_RAM = 2'd0,
    SRC_ROM = 2'd1,
    SRC_VID = 2'd2
  } src_e;
endpackage

// File: rtl/mapper_ctl_reg.sv
module mapper_ctl_reg
  import mapper_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [CTL_W-1:0] d_i,
  output logic [CTL_W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (we_i) q_o <= d_i;
  end
endmodule

// File: rtl/mapper_window_decode.sv
module mapper_window_decode
  import mapper_pkg::*;
(
  input  logic [CTL_W-1:0]  ctl_i,
  input  logic [ADDR_W-1:0] addr_i,
  output src_e              src_o,
  output logic [RAM_AW-1:0] ram_addr_o,
  output logic [ROM_AW-1:0] rom_addr_o,
  output logic              vid_hi_o
);
  logic [WIN_W-1:0]  idx;
  logic [OFF_W-1:0]  off;
  logic [WIN_W-1:0]  vid_win;
  logic [BANK_W-1:0] bank;
  logic              vid_hit, rom_hit;

  always_comb begin
    idx     = addr_i[ADDR_W-1 -: WIN_W];
    off     = addr_i[OFF_W-1:0];
    vid_win = ctl_i[CB_VID_MOVE] ? VID_WIN_ALT : VID_WIN_DEF;
    vid_hit = !ctl_i[CB_VID_OFF] && (idx == vid_win);
    rom_hit = !ctl_i[CB_ROM_OFF] && (idx >= ROM_WIN_FIRST) && (idx <= ROM_WIN_LAST);
    // upper half uses a fixed bank; lower half takes S5:S1:S0
    bank    = idx[WIN_W-1] ? UPPER_BANK
                           : {ctl_i[CB_BANK2], ctl_i[CB_BANK1], ctl_i[CB_BANK0]};
    if (vid_hit)      src_o = SRC_VID;
    else if (rom_hit) src_o = SRC_ROM;
    else              src_o = SRC_RAM;
    ram_addr_o = {bank, idx[WIN_W-2:0], off};
    rom_addr_o = {idx[ROM_PG_W-1:0], off};
    vid_hi_o   = off[OFF_W-1];
  end
endmodule

// File: rtl/mapper_path.sv
module mapper_path
  import mapper_pkg::*;
(
  input  logic strobe_i,
  input  src_e src_i,
  input  logic vid_hi_i,
  output logic ram_en_o,
  output logic rom_o,
  output logic vid_lo_o,
  output logic vid_hi_o
);
  assign ram_en_o = strobe_i && (src_i == SRC_RAM);
  assign rom_o    = strobe_i && (src_i == SRC_ROM);
  assign vid_lo_o = strobe_i && (src_i == SRC_VID) && !vid_hi_i;
  assign vid_hi_o = strobe_i && (src_i == SRC_VID) &&  vid_hi_i;
endmodule

// File: rtl/bank_window_mapper.sv
module bank_window_mapper
  import mapper_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              latch_we_i,
  input  logic [7:0]        latch_data_i,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  input  logic              mem_rd_i,
  input  logic              mem_wr_i,
  output logic              rd_ram_en_o,
  output logic [RAM_AW-1:0] rd_ram_addr_o,
  output logic              rd_rom_en_o,
  output logic [ROM_AW-1:0] rd_rom_addr_o,
  output logic              rd_vid_lo_o,
  output logic              rd_vid_hi_o,
  output logic              wr_ram_en_o,
  output logic [RAM_AW-1:0] wr_ram_addr_o,
  output logic              wr_discard_o,
  output logic              wr_vid_lo_o,
  output logic              wr_vid_hi_o
);
  logic [CTL_W-1:0]  latch_q;
  src_e              src;
  logic [RAM_AW-1:0] ram_addr;
  logic              vid_hi_sel;
  logic              unused_hi;
  logic [1:0]        strobe, ram_en, rom_hit, v_lo, v_hi;

  assign unused_hi = ^latch_data_i[7:CTL_W];

  mapper_ctl_reg i_ctl (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .we_i  (latch_we_i),
    .d_i   (latch_data_i[CTL_W-1:0]),
    .q_o   (latch_q)
  );

  mapper_window_decode i_dec (
    .ctl_i     (latch_q),
    .addr_i    (cpu_addr_i),
    .src_o     (src),
    .ram_addr_o(ram_addr),
    .rom_addr_o(rd_rom_addr_o),
    .vid_hi_o  (vid_hi_sel)
  );

  // path 0 = read, path 1 = write
  assign strobe = {mem_wr_i, mem_rd_i};

  for (genvar g = 0; g < 2; g++) begin : g_path
    mapper_path i_path (
      .strobe_i(strobe[g]),
      .src_i   (src),
      .vid_hi_i(vid_hi_sel),
      .ram_en_o(ram_en[g]),
      .rom_o   (rom_hit[g]),
      .vid_lo_o(v_lo[g]),
      .vid_hi_o(v_hi[g])
    );
  end

  assign rd_ram_en_o   = ram_en[0];
  assign rd_rom_en_o   = rom_hit[0];
  assign rd_vid_lo_o   = v_lo[0];
  assign rd_vid_hi_o   = v_hi[0];
  assign rd_ram_addr_o = ram_addr;
  assign wr_ram_en_o   = ram_en[1];
  assign wr_discard_o  = rom_hit[1];
  assign wr_vid_lo_o   = v_lo[1];
  assign wr_vid_hi_o   = v_hi[1];
  assign wr_ram_addr_o = ram_addr;
endmodule

// File: rtl/mapper_checker.sv
module mapper_checker
  import mapper_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              latch_we_i,
  input logic [7:0]        latch_data_i,
  input logic [ADDR_W-1:0] cpu_addr_i,
  input logic              mem_rd_i,
  input logic              mem_wr_i,
  input logic              rd_ram_en_o,
  input logic              rd_rom_en_o,
  input logic              rd_vid_lo_o,
  input logic              rd_vid_hi_o,
  input logic              wr_ram_en_o,
  input logic              wr_discard_o,
  input logic              wr_vid_lo_o,
  input logic              wr_vid_hi_o,
  input logic [CTL_W-1:0]  latch_q
);
  AST_RD_ONE_TARGET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({rd_ram_en_o, rd_rom_en_o, rd_vid_lo_o, rd_vid_hi_o})); // R7
  AST_WR_ONE_TARGET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({wr_ram_en_o, wr_discard_o, wr_vid_lo_o, wr_vid_hi_o})); // R9
  AST_RD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_rd_i |-> !(rd_ram_en_o || rd_rom_en_o || rd_vid_lo_o || rd_vid_hi_o)); // R11
  AST_WR_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_wr_i |-> !(wr_ram_en_o || wr_discard_o || wr_vid_lo_o || wr_vid_hi_o)); // R11
  AST_CTL_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    latch_we_i |=> latch_q == $past(latch_data_i[CTL_W-1:0])); // R2
  AST_CTL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !latch_we_i |=> $stable(latch_q)); // R11
  AST_ROM_WINDOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_rom_en_o |-> (cpu_addr_i[15:14] == 2'b10) && !latch_q[CB_ROM_OFF]); // R8
  AST_VID_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    latch_q[CB_VID_OFF] |-> !(rd_vid_lo_o || rd_vid_hi_o || wr_vid_lo_o || wr_vid_hi_o)); // R5
endmodule

bind bank_window_mapper mapper_checker i_mapper_checker (.*);

// File: tb/test_bank_window_mapper.sv
module test_bank_window_mapper;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        latch_we_i = 1'b0;
  logic [7:0]  latch_data_i = '0;
  logic [15:0] cpu_addr_i = '0;
  logic        mem_rd_i = 1'b0;
  logic        mem_wr_i = 1'b0;
  logic        rd_ram_en_o, rd_rom_en_o, rd_vid_lo_o, rd_vid_hi_o;
  logic [17:0] rd_ram_addr_o, wr_ram_addr_o;
  logic [13:0] rd_rom_addr_o;
  logic        wr_ram_en_o, wr_discard_o, wr_vid_lo_o, wr_vid_hi_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk_i = ~clk_i;

  bank_window_mapper i_bank_window_mapper (.*);

  // {ctl[7:0], addr[15:0], rd_kind[1:0], rd_val[17:0], wr_kind[1:0], wr_val[17:0]}
  // rd_kind: 0 RAM addr, 1 ROM addr, 2 video low, 3 video high
  // wr_kind: 0 RAM addr, 1 discard,  2 video low, 3 video high
  localparam int NV = 20;
  localparam logic [63:0] VEC [NV] = '{
    {8'h00, 16'h0123, 2'd0, 18'h00123, 2'd0, 18'h00123}, // R1 R3
    {8'h00, 16'h8456, 2'd1, 18'h00456, 2'd1, 18'h00000}, // R1 R8 R9
    {8'h00, 16'hF123, 2'd2, 18'h00000, 2'd2, 18'h00000}, // R1 R10
    {8'h00, 16'hF923, 2'd3, 18'h00000, 2'd3, 18'h00000}, // R10
    {8'h03, 16'h5ABC, 2'd0, 18'h1DABC, 2'd0, 18'h1DABC}, // R3
    {8'h20, 16'h2001, 2'd0, 18'h22001, 2'd0, 18'h22001}, // R3
    {8'h23, 16'h7FFF, 2'd0, 18'h3FFFF, 2'd0, 18'h3FFFF}, // R3
    {8'h04, 16'h9010, 2'd0, 18'h19010, 2'd0, 18'h19010}, // R4
    {8'h04, 16'hB777, 2'd0, 18'h1B777, 2'd0, 18'h1B777}, // R4
    {8'h08, 16'hF800, 2'd0, 18'h1F800, 2'd0, 18'h1F800}, // R5
    {8'h10, 16'h8100, 2'd2, 18'h00000, 2'd2, 18'h00000}, // R6 R7
    {8'h10, 16'h8A00, 2'd3, 18'h00000, 2'd3, 18'h00000}, // R6 R10
    {8'h10, 16'h9ABC, 2'd1, 18'h01ABC, 2'd1, 18'h00000}, // R8 R9
    {8'h10, 16'hF000, 2'd0, 18'h1F000, 2'd0, 18'h1F000}, // R6
    {8'h18, 16'h8000, 2'd1, 18'h00000, 2'd1, 18'h00000}, // R5 R7
    {8'h1C, 16'h8000, 2'd0, 18'h18000, 2'd0, 18'h18000}, // R4 R7
    {8'hC0, 16'h8004, 2'd1, 18'h00004, 2'd1, 18'h00000}, // R2
    {8'hFF, 16'h1234, 2'd0, 18'h39234, 2'd0, 18'h39234}, // R2 R3
    {8'h00, 16'hB001, 2'd1, 18'h03001, 2'd1, 18'h00000}, // R8
    {8'h00, 16'hC000, 2'd0, 18'h1C000, 2'd0, 18'h1C000}  // R3
  };

  function automatic string vec_req(int i);
    case (i)
      0, 2:          return "R1";
      1:             return "R8";
      3, 11:         return "R10";
      4, 5, 6, 17, 19: return "R3";
      7, 8, 15:      return "R4";
      9, 14:         return "R5";
      10, 13:        return "R6";
      12, 18:        return "R9";
      default:       return "R2";
    endcase
  endfunction

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [20:0] rd_obs();
    logic [1:0]  k;
    logic [17:0] v;
    logic        one;
    one = ($countones({rd_ram_en_o, rd_rom_en_o, rd_vid_lo_o, rd_vid_hi_o}) == 1);
    k = rd_vid_hi_o ? 2'd3 : rd_vid_lo_o ? 2'd2 : rd_rom_en_o ? 2'd1 : 2'd0;
    v = rd_ram_en_o ? rd_ram_addr_o : rd_rom_en_o ? {4'b0, rd_rom_addr_o} : 18'd0;
    return {one, k, v};
  endfunction

  function automatic logic [20:0] wr_obs();
    logic [1:0]  k;
    logic [17:0] v;
    logic        one;
    one = ($countones({wr_ram_en_o, wr_discard_o, wr_vid_lo_o, wr_vid_hi_o}) == 1);
    k = wr_vid_hi_o ? 2'd3 : wr_vid_lo_o ? 2'd2 : wr_discard_o ? 2'd1 : 2'd0;
    v = wr_ram_en_o ? wr_ram_addr_o : 18'd0;
    return {one, k, v};
  endfunction

  task automatic write_ctl(logic [7:0] d);
    @(negedge clk_i);
    latch_we_i   = 1'b1;
    latch_data_i = d;
    @(negedge clk_i);
    latch_we_i   = 1'b0;
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    mem_rd_i = 1'b1;
    mem_wr_i = 1'b1;
    cpu_addr_i = 16'h8000;
    #5;
    // R1: reset state visible while reset is held
    check("R1", "reset read 8000", {11'd0, rd_obs()}, {11'd0, 1'b1, 2'd1, 18'h00000});
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    cpu_addr_i = 16'h0000;
    #5;
    check("R1", "reset read 0000", {11'd0, rd_obs()}, {11'd0, 1'b1, 2'd0, 18'h00000});

    for (int i = 0; i < NV; i++) begin
      write_ctl(VEC[i][63:56]);
      cpu_addr_i = VEC[i][55:40];
      #5;
      check(vec_req(i), $sformatf("vec %0d read", i),
            {11'd0, rd_obs()}, {11'd0, 1'b1, VEC[i][39:20]});
      check(vec_req(i), $sformatf("vec %0d write", i),
            {11'd0, wr_obs()}, {11'd0, 1'b1, VEC[i][19:0]});
    end

    // R11: new control value applies only after the edge
    write_ctl(8'h00);
    cpu_addr_i = 16'h8100;
    latch_we_i = 1'b1;
    latch_data_i = 8'h10;
    #5;
    check("R11", "before edge", {11'd0, rd_obs()}, {11'd0, 1'b1, 2'd1, 18'h00100});
    @(negedge clk_i);
    latch_we_i = 1'b0;
    #5;
    check("R11", "after edge", {11'd0, rd_obs()}, {11'd0, 1'b1, 2'd2, 18'h00000});

    // R11: outputs gated by strobes
    mem_rd_i = 1'b0;
    #2;
    check("R11", "no read strobe",
          {28'd0, rd_ram_en_o, rd_rom_en_o, rd_vid_lo_o, rd_vid_hi_o}, 32'd0);
    check("R10", "write video low with read idle", {11'd0, wr_obs()},
          {11'd0, 1'b1, 2'd2, 18'h00000});
    mem_wr_i = 1'b0;
    mem_rd_i = 1'b1;
    #2;
    check("R11", "no write strobe",
          {28'd0, wr_ram_en_o, wr_discard_o, wr_vid_lo_o, wr_vid_hi_o}, 32'd0);
    mem_wr_i = 1'b1;

    // R1: reset clears a non-zero control value
    write_ctl(8'h1C);
    @(negedge clk_i);
    rst_ni = 1'b0;
    cpu_addr_i = 16'hF400;
    #5;
    check("R1", "reset clears control", {11'd0, rd_obs()}, {11'd0, 1'b1, 2'd2, 18'h00000});
    rst_ni = 1'b1;

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule